// File: doc/BRIEF.md
# Duplex-Aware Transmit Deferral Controller

This block decides the cycle in which an Ethernet MAC may begin each transmit attempt. It watches the MAC's own transmit activity, the receive carrier and the collision input. It issues a one-cycle start grant once the inter-packet gap has elapsed and any collision backoff has run out. Frame serialisation, preamble, CRC and PHY signalling are handled elsewhere. The requester holds its request high until it is granted, and then raises its transmit-active signal.

In half-duplex mode, the gap timer waits until both the MAC's own transmit activity and the receive carrier have gone quiet. Carrier that appears in a short window right after a transmission is treated as an echo and ignored. Each collision increments an attempt count and starts a randomised backoff. In full-duplex mode, receive carrier and the collision line have no effect, the gap timer starts as soon as the MAC's own transmission ends, and there is no post-transmit window. A test control forces a collision on every attempt in either mode, which drives the frame to a retry error.

Top module: `tx_defer_ctrl`

## Requirements
- R1: Full-duplex behaviour applies whenever `fdxEnable` or `fdxNegotiated` is high. Half-duplex behaviour applies only when both are low.
- R2: `txGrant` is high for exactly one cycle at a time. It is never asserted in a cycle following one where `txActive` was high. After a grant, no further grant is issued until `txActive` has been seen high.
- R3: In half-duplex mode, with the request pending, `txGrant` rises `IFG_CYCLES+1` clock edges after the later of two events: `txActive` falling, or sensed `rxCarrier` dropping.
- R4: In half-duplex mode, `rxCarrier` present during the first `BLIND_CYCLES` edges after `txActive` falls is ignored by the gap timer.
- R5: In full-duplex mode, `rxCarrier` is ignored. With the request pending, `txGrant` rises `IFG_CYCLES+1` edges after `txActive` falls.
- R6: In full-duplex mode, `colIn` has no effect, and `attemptCnt` does not change while it is asserted during a transmission.
- R7: In half-duplex mode, `colIn` during a transmission increments `attemptCnt` once per attempt, however long it stays high. A transmission that ends without a collision clears `attemptCnt` to 0 on the edge after `txActive` falls.
- R8: While `forceCol` is high, every attempt counts as collided in either mode, one edge after `txActive` rises.
- R9: On the `MAX_ATTEMPTS`-th collision of a frame (16 by default), `retryErr` is high for one cycle and `attemptCnt` returns to 0. No grant is issued until `txReq` has been low for at least one cycle.
- R10: After collision number n, the next grant waits an extra n' slot times of `SLOT_CYCLES` each. Here n' is a pseudo-random value masked to min(n,10) bits, so the wait never exceeds `IFG_CYCLES+2+(2^min(n,10)-1)*SLOT_CYCLES` edges after `txActive` falls.
- R11: While `rstN` is low, `txGrant`, `retryErr` and `attemptCnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fdxEnable | input | 1 | Explicit full-duplex enable |
| fdxNegotiated | input | 1 | Full duplex resolved by link negotiation |
| txReq | input | 1 | A frame is waiting to be sent |
| txActive | input | 1 | The MAC is transmitting |
| rxCarrier | input | 1 | Receive carrier sense |
| colIn | input | 1 | Collision indication |
| forceCol | input | 1 | Test control: collide on every attempt |
| txGrant | output | 1 | One-cycle permission to start an attempt |
| retryErr | output | 1 | One-cycle pulse: frame dropped after too many collisions |
| attemptCnt | output | $clog2(MAX_ATTEMPTS+1) (5) | Collided attempts so far on the current frame |

## Verification
A table of gap scenarios places a carrier burst of varying length at the end of a transmission. The bursts are none, shorter than the blinding window, exactly the window, longer than the window, and much longer. Each burst is run in half-duplex, explicit full-duplex and negotiated full-duplex modes. The measured grant delays show whether the echo window is applied, whether the gap restarts at carrier drop, and whether full-duplex ignores carrier.

Directed runs then cover the following:
- A long collision burst, which tells one-per-attempt counting from per-cycle counting.
- A collision in full-duplex mode, which must leave the count untouched.
- A forced-collision series to the retry limit, which checks that each backoff stays inside its growing bound and that the frame is dropped until the request is withdrawn.

// File: rtl/tx_defer_pkg.sv
package tx_defer_pkg;
  localparam int EXP_W  = 8;   // width of backoff exponent carried to the datapath
  localparam int LFSR_W = 10;  // pseudo-random source width, also the backoff mask cap

  typedef struct packed {
    logic             gapClear;     // medium busy: restart the gap timer
    logic             blindLoad;    // own transmission in half duplex: arm echo window
    logic             backoffLoad;  // collision below the limit: start a backoff
    logic [EXP_W-1:0] backoffExp;   // attempt number selecting the mask width
  } defer_strobe_t;
endpackage

// File: rtl/tx_defer_datapath.sv
module tx_defer_datapath
  import tx_defer_pkg::*;
#(
  parameter int IFG_CYCLES   = 480,
  parameter int BLIND_CYCLES = 200,
  parameter int SLOT_CYCLES  = 2560
) (
  input  logic          clk,
  input  logic          rstN,
  input  defer_strobe_t strobes,
  output logic          gapDone,
  output logic          blinding,
  output logic          backoffDone
);
  localparam int GAP_W   = $clog2(IFG_CYCLES + 1);
  localparam int BLIND_W = $clog2(BLIND_CYCLES + 1);
  localparam int SLOT_W  = $clog2(SLOT_CYCLES + 1);

  logic [GAP_W-1:0]   gapCnt;
  logic [BLIND_W-1:0] blindCnt;
  logic [LFSR_W-1:0]  lfsr;
  logic [LFSR_W-1:0]  slotsLeft;
  logic [SLOT_W-1:0]  slotTimer;
  logic [LFSR_W-1:0]  mask;

  // mask keeps min(exponent, LFSR_W) low bits of the random value
  always_comb begin
    for (int i = 0; i < LFSR_W; i++)
      mask[i] = (strobes.backoffExp > EXP_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= '0;
      blindCnt  <= '0;
      lfsr      <= LFSR_W'(1);
      slotsLeft <= '0;
      slotTimer <= '0;
    end else begin
      // x^10 + x^7 + 1, free running
      lfsr <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[6]};

      if (strobes.gapClear)
        gapCnt <= '0;
      else if (gapCnt != GAP_W'(IFG_CYCLES))
        gapCnt <= gapCnt + GAP_W'(1);

      if (strobes.blindLoad)
        blindCnt <= BLIND_W'(BLIND_CYCLES);
      else if (blindCnt != '0)
        blindCnt <= blindCnt - BLIND_W'(1);

      if (strobes.backoffLoad) begin
        slotsLeft <= lfsr & mask;
        slotTimer <= SLOT_W'(SLOT_CYCLES);
      end else if (slotsLeft != '0) begin
        if (slotTimer <= SLOT_W'(1)) begin
          slotsLeft <= slotsLeft - LFSR_W'(1);
          slotTimer <= SLOT_W'(SLOT_CYCLES);
        end else begin
          slotTimer <= slotTimer - SLOT_W'(1);
        end
      end
    end
  end

  assign gapDone     = (gapCnt == GAP_W'(IFG_CYCLES));
  assign blinding    = (blindCnt != '0);
  assign backoffDone = (slotsLeft == '0);
endmodule

// File: rtl/tx_defer_control.sv
module tx_defer_control
  import tx_defer_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 16,
  parameter int ATT_W        = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fdx,
  input  logic             txReq,
  input  logic             txActive,
  input  logic             rxCarrier,
  input  logic             colIn,
  input  logic             forceCol,
  input  logic             gapDone,
  input  logic             blinding,
  input  logic             backoffDone,
  output defer_strobe_t    strobes,
  output logic             txGrant,
  output logic             retryErr,
  output logic [ATT_W-1:0] attemptCnt
);
  logic             txActiveQ;
  logic             awaitTx;
  logic             colSeen;
  logic             dropHold;
  logic             colEvent;
  logic             limitHit;
  logic             txEnd;
  logic             grantCond;
  logic [ATT_W-1:0] nextCnt;

  always_comb begin
    colEvent  = txActive & ~colSeen & ((colIn & ~fdx) | forceCol);
    nextCnt   = attemptCnt + ATT_W'(1);
    limitHit  = colEvent & (nextCnt == ATT_W'(MAX_ATTEMPTS));
    txEnd     = txActiveQ & ~txActive;
    grantCond = txReq & ~dropHold & ~awaitTx & ~txGrant & ~txActive
              & gapDone & backoffDone;

    strobes.gapClear    = txActive | (~fdx & rxCarrier & ~blinding);
    strobes.blindLoad   = txActive & ~fdx;
    strobes.backoffLoad = colEvent & ~limitHit;
    strobes.backoffExp  = EXP_W'(nextCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txGrant    <= 1'b0;
      retryErr   <= 1'b0;
      txActiveQ  <= 1'b0;
      awaitTx    <= 1'b0;
      colSeen    <= 1'b0;
      dropHold   <= 1'b0;
      attemptCnt <= '0;
    end else begin
      txGrant   <= grantCond;
      retryErr  <= limitHit;
      txActiveQ <= txActive;

      if (grantCond)     awaitTx <= 1'b1;
      else if (txActive) awaitTx <= 1'b0;

      if (grantCond)     colSeen <= 1'b0;
      else if (colEvent) colSeen <= 1'b1;

      if (limitHit)    dropHold <= 1'b1;
      else if (!txReq) dropHold <= 1'b0;

      if (limitHit)               attemptCnt <= '0;
      else if (colEvent)          attemptCnt <= nextCnt;
      else if (txEnd && !colSeen) attemptCnt <= '0;
    end
  end
endmodule

// File: rtl/tx_defer_ctrl.sv
module tx_defer_ctrl
  import tx_defer_pkg::*;
#(
  parameter int IFG_CYCLES   = 480,
  parameter int BLIND_CYCLES = 200,
  parameter int SLOT_CYCLES  = 2560,
  parameter int MAX_ATTEMPTS = 16,
  localparam int ATT_W       = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fdxEnable,
  input  logic             fdxNegotiated,
  input  logic             txReq,
  input  logic             txActive,
  input  logic             rxCarrier,
  input  logic             colIn,
  input  logic             forceCol,
  output logic             txGrant,
  output logic             retryErr,
  output logic [ATT_W-1:0] attemptCnt
);
  defer_strobe_t strobes;
  logic gapDone;
  logic blinding;
  logic backoffDone;
  logic fdx;

  assign fdx = fdxEnable | fdxNegotiated;

  tx_defer_control #(
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .ATT_W       (ATT_W)
  ) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .fdx        (fdx),
    .txReq      (txReq),
    .txActive   (txActive),
    .rxCarrier  (rxCarrier),
    .colIn      (colIn),
    .forceCol   (forceCol),
    .gapDone    (gapDone),
    .blinding   (blinding),
    .backoffDone(backoffDone),
    .strobes    (strobes),
    .txGrant    (txGrant),
    .retryErr   (retryErr),
    .attemptCnt (attemptCnt)
  );

  tx_defer_datapath #(
    .IFG_CYCLES  (IFG_CYCLES),
    .BLIND_CYCLES(BLIND_CYCLES),
    .SLOT_CYCLES (SLOT_CYCLES)
  ) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .gapDone    (gapDone),
    .blinding   (blinding),
    .backoffDone(backoffDone)
  );
endmodule

// File: rtl/tx_defer_ctrl_chk.sv
module tx_defer_ctrl_chk #(
  parameter int MAX_ATTEMPTS = 16,
  parameter int ATT_W        = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             fdxEnable,
  input logic             fdxNegotiated,
  input logic             txActive,
  input logic             forceCol,
  input logic             txGrant,
  input logic             retryErr,
  input logic [ATT_W-1:0] attemptCnt
);
  logic fdxMode;
  assign fdxMode = fdxEnable | fdxNegotiated;

  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txGrant |=> !txGrant);                                                  // R2
  AST_GRANT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txGrant) |-> !$past(txActive));                                   // R2
  AST_FDX_COL_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (fdxMode && !forceCol && txActive) |=> $stable(attemptCnt));            // R6
  AST_RETRY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    retryErr |-> (attemptCnt == '0));                                       // R9
  AST_RETRY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    retryErr |=> !retryErr);                                                // R9
  AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    attemptCnt < ATT_W'(MAX_ATTEMPTS));                                     // R8
endmodule

bind tx_defer_ctrl tx_defer_ctrl_chk #(
  .MAX_ATTEMPTS(MAX_ATTEMPTS),
  .ATT_W       (ATT_W)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .fdxEnable    (fdxEnable),
  .fdxNegotiated(fdxNegotiated),
  .txActive     (txActive),
  .forceCol     (forceCol),
  .txGrant      (txGrant),
  .retryErr     (retryErr),
  .attemptCnt   (attemptCnt)
);

// File: tb/tb_tx_defer_ctrl.sv
module tb_tx_defer_ctrl;
  localparam int IFG   = 8;
  localparam int BLIND = 4;
  localparam int SLOT  = 6;
  localparam int MAXA  = 16;
  localparam int ATT_W = 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic fdxEnable = 1'b0, fdxNegotiated = 1'b0, txReq = 1'b0, txActive = 1'b0;
  logic rxCarrier = 1'b0, colIn = 1'b0, forceCol = 1'b0;
  logic txGrant, retryErr;
  logic [ATT_W-1:0] attemptCnt;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tx_defer_ctrl #(.IFG_CYCLES(IFG), .BLIND_CYCLES(BLIND), .SLOT_CYCLES(SLOT),
                  .MAX_ATTEMPTS(MAXA)) dut (
    .clk(clk), .rstN(rstN), .fdxEnable(fdxEnable), .fdxNegotiated(fdxNegotiated),
    .txReq(txReq), .txActive(txActive), .rxCarrier(rxCarrier), .colIn(colIn),
    .forceCol(forceCol), .txGrant(txGrant), .retryErr(retryErr), .attemptCnt(attemptCnt));

  typedef struct packed {
    logic       fe;
    logic       fn;
    logic [7:0] car;
    logic [7:0] dly;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 8'd0,        8'(IFG + 1)},       // R3 quiet medium
    '{1'b0, 1'b0, 8'd3,        8'(IFG + 1)},       // R4 echo inside window
    '{1'b0, 1'b0, 8'(BLIND),   8'(IFG + 1)},       // R4 echo fills window
    '{1'b0, 1'b0, 8'd7,        8'(7 + IFG + 1)},   // R3 carrier past window
    '{1'b0, 1'b0, 8'd20,       8'(20 + IFG + 1)},  // R3 long carrier
    '{1'b1, 1'b0, 8'd20,       8'(IFG + 1)},       // R5 carrier ignored
    '{1'b0, 1'b1, 8'd20,       8'(IFG + 1)}        // R1 negotiated full duplex
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitGrant(output int d, input int limit);
    d = 0;
    do begin
      @(negedge clk);
      d++;
    end while (!txGrant && d < limit);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d;
    int grants;
    // R11 reset state
    repeat (3) @(negedge clk);
    check(txGrant == 1'b0, "R11 txGrant in reset", txGrant, 0);
    check(retryErr == 1'b0, "R11 retryErr in reset", retryErr, 0);
    check(attemptCnt == '0, "R11 attemptCnt in reset", attemptCnt, 0);
    rstN = 1'b1;

    // gap / echo window / duplex table
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      fdxEnable = VECS[i].fe; fdxNegotiated = VECS[i].fn;
      txReq = 1'b0; txActive = 1'b1;
      repeat (3) @(negedge clk);
      txReq = 1'b1; txActive = 1'b0; rxCarrier = (VECS[i].car != 8'd0);
      d = 0;
      do begin
        @(negedge clk);
        d++;
        if (d == int'(VECS[i].car)) rxCarrier = 1'b0;
      end while (!txGrant && d < 200);
      rxCarrier = 1'b0;
      check(d == int'(VECS[i].dly), $sformatf("R3/R4/R5/R1 vector %0d grant delay", i),
            d, int'(VECS[i].dly));
      @(negedge clk);
      check(txGrant == 1'b0, "R2 grant lasts one cycle", txGrant, 0);
      txReq = 1'b0;
    end

    // R2: no second grant without an intervening transmission
    txReq = 1'b1; grants = 0;
    repeat (30) begin @(negedge clk); if (txGrant) grants++; end
    check(grants == 0, "R2 no regrant before txActive", grants, 0);
    txReq = 1'b0;

    // R7: half-duplex collision counted once per attempt
    fdxEnable = 1'b0; fdxNegotiated = 1'b0;
    @(negedge clk); txActive = 1'b1; @(negedge clk); txActive = 1'b0;
    txReq = 1'b1;
    waitGrant(d, 100);
    check(txGrant == 1'b1, "R7 grant before collision", txGrant, 1);
    txActive = 1'b1; colIn = 1'b1;
    repeat (3) @(negedge clk);
    colIn = 1'b0;
    check(attemptCnt == 5'd1, "R7 one count per attempt", attemptCnt, 1);
    txActive = 1'b0;
    @(negedge clk);
    check(attemptCnt == 5'd1, "R7 collided end keeps count", attemptCnt, 1);
    waitGrant(d, 3000);
    check(txGrant && d <= IFG + 2 + SLOT, "R10 backoff after first collision", d, IFG + 2 + SLOT);
    txActive = 1'b1; repeat (2) @(negedge clk); txActive = 1'b0;
    @(negedge clk);
    check(attemptCnt == 5'd0, "R7 clean end clears count", attemptCnt, 0);
    txReq = 1'b0;

    // R6: full-duplex ignores the collision line
    fdxEnable = 1'b1;
    repeat (2) @(negedge clk);
    txReq = 1'b1;
    waitGrant(d, 100);
    txActive = 1'b1; colIn = 1'b1;
    repeat (3) @(negedge clk);
    check(attemptCnt == 5'd0, "R6 collision ignored in full duplex", attemptCnt, 0);
    colIn = 1'b0; txActive = 1'b0; txReq = 1'b0;
    repeat (2) @(negedge clk);

    // R8/R9/R10: forced collisions up to the retry limit
    forceCol = 1'b1; txReq = 1'b1;
    for (int k = 1; k <= MAXA; k++) begin
      int e;
      int upper;
      e = (k - 1 > 10) ? 10 : k - 1;
      upper = IFG + 2 + ((1 << e) - 1) * SLOT;
      waitGrant(d, 8000);
      if (k == 1)
        check(txGrant == 1'b1, "R8 first forced attempt granted", txGrant, 1);
      else
        check(txGrant && d >= IFG + 1 && d <= upper,
              $sformatf("R10 backoff bound attempt %0d", k), d, upper);
      txActive = 1'b1;
      @(negedge clk);
      check(attemptCnt == ((k == MAXA) ? 5'd0 : 5'(k)),
            $sformatf("R8 forced count attempt %0d", k), attemptCnt, (k == MAXA) ? 0 : k);
      check(retryErr == (k == MAXA), $sformatf("R9 retryErr attempt %0d", k),
            retryErr, (k == MAXA) ? 1 : 0);
      @(negedge clk);
      if (k == MAXA) check(retryErr == 1'b0, "R9 retryErr one cycle", retryErr, 0);
      txActive = 1'b0;
    end
    forceCol = 1'b0;
    grants = 0;
    repeat (100) begin @(negedge clk); if (txGrant) grants++; end
    check(grants == 0, "R9 dropped frame not regranted", grants, 0);
    check(attemptCnt == 5'd0, "R9 count cleared after drop", attemptCnt, 0);
    txReq = 1'b0;
    @(negedge clk);
    txReq = 1'b1;
    waitGrant(d, 50);
    check(txGrant && d <= IFG + 1, "R9 new request accepted", d, 1);
    txReq = 1'b0;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule